// File: doc/BRIEF.md
# Time-Aware Egress Gate Scheduler

This block decides, cycle by cycle, which traffic classes of one switch egress port may begin a frame. It runs a repeating time table: a list of up to `DEPTH` entries, each giving a slot length in clock ticks and a bit mask of the classes whose gate is open during that slot. After a start pulse the entries are played in order, and the table wraps back to its first entry once the configured number of entries has been used.

A class may start a frame only when three conditions hold. Its queue must be requesting, its gate must be open, and the ticks left in the current slot must cover the frame's length. The last condition is the guard band: it keeps a frame from running past the edge of its window. A frame that is refused is held. Each held frame adds one to that class's miss counter, however long it waits.

The table is double-banked. Software writes entries into the bank that is not in use and then requests a swap. The new bank and its entry count take over at the next cycle boundary, so a cycle never mixes two tables.

Top module: `tas_egress_gate`

## Requirements
- R1: After reset the scheduler is idle until the first start pulse. Every gate output and every transmit enable is 0, the slot index and slot remaining count are 0, every miss counter is 0 and no swap is pending.
- R2: A start pulse makes entry 0 active, with the remaining count loaded from that entry's duration. The count falls by one each clock, so an entry of duration D is active for exactly D clocks. The next entry in index order then becomes active, and entry 0 follows the last entry of the active count.
- R3: While the scheduler runs, `gate_open_o[c]` equals bit c of the active entry's class mask. Before the first start every bit is 0.
- R4: `tx_en_o[c]` is 1 exactly when `req_i[c]` is 1, the gate of class c is open, and `slot_rem_o` is at least the class's frame length `flen_i[c*FLEN_W +: FLEN_W]`, in ticks.
- R5: A held frame is a run of consecutive clocks in which `req_i[c]` is 1 and `tx_en_o[c]` is 0. The miss counter of class c, at `miss_cnt_o[c*MISS_W +: MISS_W]`, adds exactly one for each held frame. The increment shows on the clock after the run begins, and the counter stops at its all-ones value.
- R6: A write with `cfg_wr_i` stores the duration and mask at index `cfg_idx_i` of the inactive bank only. The entries being played are not changed.
- R7: A swap request sets `swap_pend_o` on the next clock. At the next cycle boundary the other bank and the requested entry count become active, starting from its entry 0, and `swap_pend_o` clears. A cycle boundary is the wrap after the last entry, or a start pulse.
- R8: A start pulse while running abandons the current slot. Entry 0 becomes active on the next clock with its full duration.
- R9: An entry whose stored duration is 0 is active for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of the schedule per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start or restart pulse; begins a cycle at entry 0 |
| cfg_wr_i | input | 1 | Write strobe for one entry of the inactive bank |
| cfg_idx_i | input | IDX_W | Entry index for the write |
| cfg_dur_i | input | DUR_W | Slot duration in ticks for the write |
| cfg_mask_i | input | CLASSES | Open-gate mask for the write, bit c for class c |
| swap_req_i | input | 1 | Request to switch banks at the next cycle boundary |
| swap_len_i | input | CNT_W | Number of entries in the bank being switched in (clamped to 1..DEPTH) |
| req_i | input | CLASSES | Per-class frame waiting |
| flen_i | input | CLASSES*FLEN_W | Per-class length of the waiting frame in ticks |
| gate_open_o | output | CLASSES | Per-class gate state of the active slot |
| tx_en_o | output | CLASSES | Per-class permission to start the waiting frame now |
| slot_idx_o | output | IDX_W | Index of the active entry |
| slot_rem_o | output | DUR_W | Ticks left in the active slot, counting the current one |
| swap_pend_o | output | 1 | A bank swap is waiting for a cycle boundary |
| miss_cnt_o | output | CLASSES*MISS_W | Per-class saturating held-frame counters |

## Verification
The properties assume that a swap is not requested again while one is already pending. They also assume that no entry is written in the same clock in which a swap takes effect, because either would let the table in use change in the middle of a cycle. They further assume that frame lengths fit within the duration width. The stimulus follows these assumptions. It writes entries only while idle, or while running with no swap pending, and it issues each swap request on a single clock. Every frame length is a small constant well below the duration range. Request patterns come from a shift-register sequence, so admissions at the exact guard-band boundary and long held runs both occur.

// File: rtl/tas_pkg.sv
// Package: shared defaults and helpers for the time-aware egress gate.
// Assumes nothing beyond being compiled before every module that imports it.
package tas_pkg;

    localparam int TAS_CLASSES = 8;
    localparam int TAS_DEPTH   = 8;
    localparam int TAS_DUR_W   = 32;
    localparam int TAS_FLEN_W  = 16;
    localparam int TAS_MISS_W  = 16;

    // Which of the two table banks is being played.
    typedef enum logic {
        BANK_0 = 1'b0,
        BANK_1 = 1'b1
    } tas_bank_e;

    // Width of an entry index; at least one bit.
    function automatic int tas_idx_w(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Width of an entry count able to hold the value depth.
    function automatic int tas_cnt_w(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/tas_gcl_store.sv
// Module: tas_gcl_store
// Two banks of schedule entries (duration plus class mask). There is one write
// port and two combinational read ports: A returns the mask of the active
// entry, B returns the duration of the entry that would load next.
// Assumes DEPTH is a power of two, so {bank, index} forms a dense address.
module tas_gcl_store #(
    parameter  int CLASSES = 8,
    parameter  int DEPTH   = 8,
    parameter  int DUR_W   = 32,
    localparam int IDX_W   = tas_pkg::tas_idx_w(DEPTH),
    localparam int ADDR_W  = IDX_W + 1,
    localparam int ENTRIES = 2 ** ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               wr_bank_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [DUR_W-1:0]   wr_dur_i,
    input  logic [CLASSES-1:0] wr_mask_i,
    input  logic               rda_bank_i,
    input  logic [IDX_W-1:0]   rda_idx_i,
    output logic [CLASSES-1:0] rda_mask_o,
    input  logic               rdb_bank_i,
    input  logic [IDX_W-1:0]   rdb_idx_i,
    output logic [DUR_W-1:0]   rdb_dur_o
);

    logic [DUR_W-1:0]   dur_q  [ENTRIES];
    logic [CLASSES-1:0] mask_q [ENTRIES];
    logic [ADDR_W-1:0]  wr_addr;
    logic [ADDR_W-1:0]  rda_addr;
    logic [ADDR_W-1:0]  rdb_addr;

    assign wr_addr  = {wr_bank_i,  wr_idx_i};
    assign rda_addr = {rda_bank_i, rda_idx_i};
    assign rdb_addr = {rdb_bank_i, rdb_idx_i};

    // Entry storage: cleared by reset, one entry written per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                dur_q[e]  <= '0;
                mask_q[e] <= '0;
            end
        end else if (wr_en_i) begin
            dur_q[wr_addr]  <= wr_dur_i;
            mask_q[wr_addr] <= wr_mask_i;
        end
    end

    // Read ports: the active mask and the duration about to load.
    assign rda_mask_o = mask_q[rda_addr];
    assign rdb_dur_o  = dur_q[rdb_addr];

endmodule

// File: rtl/tas_slot_seq.sv
// Module: tas_slot_seq
// Walks the schedule. It keeps the active bank, entry index and ticks left,
// and loads the next entry when a slot ends or a start pulse arrives. A
// pending bank swap takes effect only on a wrap to entry 0.
// Assumes the store answers the next-entry read in the same clock, and that
// swap requests are not repeated while one is pending.
module tas_slot_seq
    import tas_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int DUR_W = 32,
    localparam int IDX_W = tas_idx_w(DEPTH),
    localparam int CNT_W = tas_cnt_w(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             swap_req_i,
    input  logic [CNT_W-1:0] swap_len_i,
    input  logic [DUR_W-1:0] nxt_dur_i,
    output logic             running_o,
    output logic             cur_bank_o,
    output logic [IDX_W-1:0] cur_idx_o,
    output logic             nxt_bank_o,
    output logic [IDX_W-1:0] nxt_idx_o,
    output logic [DUR_W-1:0] rem_o,
    output logic             pend_o
);

    tas_bank_e        bank_q;
    tas_bank_e        bank_nx;
    logic             running_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_nx;
    logic [DUR_W-1:0] rem_q;
    logic [DUR_W-1:0] dur_floor;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] plen_q;
    logic [CNT_W-1:0] len_clamped;
    logic             pend_q;
    logic             slot_end;
    logic             boundary;
    logic             last_entry;
    logic             wrap;
    logic             take_swap;

    // Decide whether this clock closes a slot and where the walk goes next.
    assign slot_end   = running_q && (rem_q == DUR_W'(1));
    assign boundary   = start_i || slot_end;
    assign last_entry = (CNT_W'(idx_q) + CNT_W'(1)) == len_q;
    assign wrap       = start_i || last_entry;
    assign take_swap  = boundary && wrap && pend_q;
    assign idx_nx     = wrap ? '0 : idx_q + IDX_W'(1);
    assign dur_floor  = (nxt_dur_i == '0) ? DUR_W'(1) : nxt_dur_i;

    // Bank selection for the entry that loads next.
    always_comb begin
        bank_nx = bank_q;
        if (take_swap) begin
            bank_nx = (bank_q == BANK_0) ? BANK_1 : BANK_0;
        end
    end

    // Requested entry count limited to 1..DEPTH.
    always_comb begin
        if (swap_len_i == '0) begin
            len_clamped = CNT_W'(1);
        end else if (swap_len_i > CNT_W'(DEPTH)) begin
            len_clamped = CNT_W'(DEPTH);
        end else begin
            len_clamped = swap_len_i;
        end
    end

    // Run flag: set by the first start pulse and held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
        end else if (start_i) begin
            running_q <= 1'b1;
        end
    end

    // Slot position: load a new entry at a boundary, otherwise count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            rem_q  <= '0;
            bank_q <= BANK_0;
        end else if (boundary) begin
            idx_q  <= idx_nx;
            rem_q  <= dur_floor;
            bank_q <= bank_nx;
        end else if (running_q) begin
            rem_q  <= rem_q - DUR_W'(1);
        end
    end

    // Active entry count: replaced only when a swap lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= CNT_W'(1);
        end else if (take_swap) begin
            len_q <= plen_q;
        end
    end

    // Swap request: remember it and its count until a wrap consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            plen_q <= CNT_W'(1);
        end else if (swap_req_i) begin
            pend_q <= 1'b1;
            plen_q <= len_clamped;
        end else if (take_swap) begin
            pend_q <= 1'b0;
        end
    end

    assign running_o  = running_q;
    assign cur_bank_o = bank_q;
    assign cur_idx_o  = idx_q;
    assign nxt_bank_o = bank_nx;
    assign nxt_idx_o  = idx_nx;
    assign rem_o      = rem_q;
    assign pend_o     = pend_q;

endmodule

// File: rtl/tas_gate_admit.sv
// Module: tas_gate_admit
// Per-class admission. A class is open when the scheduler runs and its mask
// bit is set. It may start a frame only if the frame fits in the ticks left,
// which is the guard band. Each held frame is counted once in a saturating
// counter.
// Assumes FLEN_W <= DUR_W.
module tas_gate_admit #(
    parameter int CLASSES = 8,
    parameter int DUR_W   = 32,
    parameter int FLEN_W  = 16,
    parameter int MISS_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      running_i,
    input  logic [CLASSES-1:0]        mask_i,
    input  logic [DUR_W-1:0]          rem_i,
    input  logic [CLASSES-1:0]        req_i,
    input  logic [CLASSES*FLEN_W-1:0] flen_i,
    output logic [CLASSES-1:0]        gate_open_o,
    output logic [CLASSES-1:0]        tx_en_o,
    output logic [CLASSES*MISS_W-1:0] miss_cnt_o
);

    for (genvar c = 0; c < CLASSES; c++) begin : g_class
        logic [FLEN_W-1:0] flen_c;
        logic              open_c;
        logic              fits_c;
        logic              tx_c;
        logic              held_nx;
        logic              held_q;
        logic [MISS_W-1:0] cnt_q;

        // Guard band: the frame must end no later than the slot does.
        assign flen_c  = flen_i[c*FLEN_W +: FLEN_W];
        assign open_c  = running_i & mask_i[c];
        assign fits_c  = DUR_W'(flen_c) <= rem_i;
        assign tx_c    = req_i[c] & open_c & fits_c;
        assign held_nx = req_i[c] & ~tx_c;

        // Held-frame tracker: marks that the current wait is already counted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_q <= 1'b0;
            end else begin
                held_q <= held_nx;
            end
        end

        // Miss counter: one step on the first clock of each wait, saturating.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (held_nx && !held_q && (cnt_q != '1)) begin
                cnt_q <= cnt_q + MISS_W'(1);
            end
        end

        assign gate_open_o[c]                 = open_c;
        assign tx_en_o[c]                     = tx_c;
        assign miss_cnt_o[c*MISS_W +: MISS_W] = cnt_q;
    end

endmodule

// File: rtl/tas_egress_gate.sv
// Module: tas_egress_gate (top)
// Egress gate controller for one port. It connects the double-banked table
// store, the slot sequencer and the per-class admission logic. Writes always
// go to the bank that is not being played.
// Assumes a write does not coincide with the clock in which a swap lands.
module tas_egress_gate
    import tas_pkg::*;
#(
    parameter  int CLASSES = TAS_CLASSES,
    parameter  int DEPTH   = TAS_DEPTH,
    parameter  int DUR_W   = TAS_DUR_W,
    parameter  int FLEN_W  = TAS_FLEN_W,
    parameter  int MISS_W  = TAS_MISS_W,
    localparam int IDX_W   = tas_idx_w(DEPTH),
    localparam int CNT_W   = tas_cnt_w(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      cfg_wr_i,
    input  logic [IDX_W-1:0]          cfg_idx_i,
    input  logic [DUR_W-1:0]          cfg_dur_i,
    input  logic [CLASSES-1:0]        cfg_mask_i,
    input  logic                      swap_req_i,
    input  logic [CNT_W-1:0]          swap_len_i,
    input  logic [CLASSES-1:0]        req_i,
    input  logic [CLASSES*FLEN_W-1:0] flen_i,
    output logic [CLASSES-1:0]        gate_open_o,
    output logic [CLASSES-1:0]        tx_en_o,
    output logic [IDX_W-1:0]          slot_idx_o,
    output logic [DUR_W-1:0]          slot_rem_o,
    output logic                      swap_pend_o,
    output logic [CLASSES*MISS_W-1:0] miss_cnt_o
);

    logic               running;
    logic               cur_bank;
    logic               nxt_bank;
    logic [IDX_W-1:0]   cur_idx;
    logic [IDX_W-1:0]   nxt_idx;
    logic [DUR_W-1:0]   nxt_dur;
    logic [DUR_W-1:0]   rem;
    logic [CLASSES-1:0] cur_mask;

    // Sequencer: tracks slot position and bank swaps.
    tas_slot_seq #(
        .DEPTH (DEPTH),
        .DUR_W (DUR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .swap_req_i (swap_req_i),
        .swap_len_i (swap_len_i),
        .nxt_dur_i  (nxt_dur),
        .running_o  (running),
        .cur_bank_o (cur_bank),
        .cur_idx_o  (cur_idx),
        .nxt_bank_o (nxt_bank),
        .nxt_idx_o  (nxt_idx),
        .rem_o      (rem),
        .pend_o     (swap_pend_o)
    );

    // Table store: the write targets the inactive bank.
    tas_gcl_store #(
        .CLASSES (CLASSES),
        .DEPTH   (DEPTH),
        .DUR_W   (DUR_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (cfg_wr_i),
        .wr_bank_i  (~cur_bank),
        .wr_idx_i   (cfg_idx_i),
        .wr_dur_i   (cfg_dur_i),
        .wr_mask_i  (cfg_mask_i),
        .rda_bank_i (cur_bank),
        .rda_idx_i  (cur_idx),
        .rda_mask_o (cur_mask),
        .rdb_bank_i (nxt_bank),
        .rdb_idx_i  (nxt_idx),
        .rdb_dur_o  (nxt_dur)
    );

    // Admission: gate state, guard band and miss accounting per class.
    tas_gate_admit #(
        .CLASSES (CLASSES),
        .DUR_W   (DUR_W),
        .FLEN_W  (FLEN_W),
        .MISS_W  (MISS_W)
    ) u_admit (
        .clk         (clk),
        .rst_n       (rst_n),
        .running_i   (running),
        .mask_i      (cur_mask),
        .rem_i       (rem),
        .req_i       (req_i),
        .flen_i      (flen_i),
        .gate_open_o (gate_open_o),
        .tx_en_o     (tx_en_o),
        .miss_cnt_o  (miss_cnt_o)
    );

    assign slot_idx_o = cur_idx;
    assign slot_rem_o = rem;

endmodule

// File: rtl/tas_egress_gate_chk.sv
// Module: tas_egress_gate_chk
// Property checker bound to tas_egress_gate. It watches the ports and the
// internal run flag.
// Assumes the synchronous reset is held for at least one clock edge.
module tas_egress_gate_chk #(
    parameter  int CLASSES = 8,
    parameter  int DEPTH   = 8,
    parameter  int DUR_W   = 32,
    parameter  int MISS_W  = 16,
    localparam int IDX_W   = tas_pkg::tas_idx_w(DEPTH)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_i,
    input logic                      swap_req_i,
    input logic                      running,
    input logic [CLASSES-1:0]        req_i,
    input logic [CLASSES-1:0]        gate_open_o,
    input logic [CLASSES-1:0]        tx_en_o,
    input logic [IDX_W-1:0]          slot_idx_o,
    input logic [DUR_W-1:0]          slot_rem_o,
    input logic                      swap_pend_o,
    input logic [CLASSES*MISS_W-1:0] miss_cnt_o
);

    logic past_ok;

    // History guard: $past is trusted only after one clock out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    p_tx_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_o & ~gate_open_o) == '0);

    p_tx_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_o & ~req_i) == '0);

    p_closed_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (gate_open_o == '0));

    p_rem_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (slot_rem_o != '0));

    p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && running && !start_i && (slot_rem_o > DUR_W'(1)))
        |=> ((slot_rem_o == $past(slot_rem_o) - DUR_W'(1))
             && (slot_idx_o == $past(slot_idx_o))));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> ((slot_idx_o == '0) && running));

    p_pend_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        swap_req_i |=> swap_pend_o);

    for (genvar c = 0; c < CLASSES; c++) begin : g_miss
        p_miss_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> ((miss_cnt_o[c*MISS_W +: MISS_W]
                          - $past(miss_cnt_o[c*MISS_W +: MISS_W])) <= MISS_W'(1)));
    end

endmodule

bind tas_egress_gate tas_egress_gate_chk #(
    .CLASSES (CLASSES),
    .DEPTH   (DEPTH),
    .DUR_W   (DUR_W),
    .MISS_W  (MISS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .swap_req_i  (swap_req_i),
    .running     (running),
    .req_i       (req_i),
    .gate_open_o (gate_open_o),
    .tx_en_o     (tx_en_o),
    .slot_idx_o  (slot_idx_o),
    .slot_rem_o  (slot_rem_o),
    .swap_pend_o (swap_pend_o),
    .miss_cnt_o  (miss_cnt_o)
);

// File: tb/tas_egress_gate_tb.sv
`timescale 1ns/1ps
// Scoreboard bench. The driver task applies one clock of stimulus and pushes
// the expected outputs for that clock, taken from a behavioural model of the
// requirements. The monitor pops each item and compares it mid-cycle.
module tas_egress_gate_tb;

    localparam int NC = 8;
    localparam int FW = 16;
    localparam int MW = 16;

    typedef struct packed {
        logic [7:0]     open;
        logic [7:0]     tx;
        logic [2:0]     idx;
        logic [31:0]    rem;
        logic           pend;
        logic [NC*MW-1:0] miss;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start_i, cfg_wr_i, swap_req_i;
    logic [2:0]        cfg_idx_i;
    logic [31:0]       cfg_dur_i;
    logic [7:0]        cfg_mask_i;
    logic [3:0]        swap_len_i;
    logic [7:0]        req_i;
    logic [NC*FW-1:0]  flen_i;
    logic [7:0]        gate_open_o, tx_en_o;
    logic [2:0]        slot_idx_o;
    logic [31:0]       slot_rem_o;
    logic              swap_pend_o;
    logic [NC*MW-1:0]  miss_cnt_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string phase    = "start-up";
    exp_t  sb_q[$];

    // Behavioural model state.
    int        flen_tab[NC] = '{1, 2, 3, 6, 1, 2, 4, 1};
    int        m_dur[2][8];
    logic [7:0] m_msk[2][8];
    int        m_bank, m_idx, m_rem, m_len, m_plen, m_miss[NC];
    bit        m_run, m_pend, m_held[NC];
    logic [7:0] lf = 8'hA5;

    always #10 clk = ~clk;

    tas_egress_gate u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_wr_i(cfg_wr_i),
        .cfg_idx_i(cfg_idx_i), .cfg_dur_i(cfg_dur_i), .cfg_mask_i(cfg_mask_i),
        .swap_req_i(swap_req_i), .swap_len_i(swap_len_i), .req_i(req_i),
        .flen_i(flen_i), .gate_open_o(gate_open_o), .tx_en_o(tx_en_o),
        .slot_idx_o(slot_idx_o), .slot_rem_o(slot_rem_o),
        .swap_pend_o(swap_pend_o), .miss_cnt_o(miss_cnt_o)
    );

    task automatic check(input string rq, input logic [NC*MW-1:0] act,
                         input logic [NC*MW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", rq, phase, act, exp);
        end
    endtask

    function automatic logic [7:0] rnd();
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        return lf;
    endfunction

    // Driver: one clock of stimulus plus its expected outputs.
    task automatic step(input logic st, input logic sw, input int slen,
                        input logic [7:0] rq, input logic wr, input int widx,
                        input int wdur, input logic [7:0] wmsk);
        exp_t e;
        int   nidx;
        bit   wrap_m, take, h;
        @(negedge clk);
        start_i = st; swap_req_i = sw; swap_len_i = 4'(slen); req_i = rq;
        cfg_wr_i = wr; cfg_idx_i = 3'(widx); cfg_dur_i = 32'(wdur); cfg_mask_i = wmsk;
        e.open = m_run ? m_msk[m_bank][m_idx] : 8'h00;
        for (int c = 0; c < NC; c++)
            e.tx[c] = rq[c] & e.open[c] & (flen_tab[c] <= m_rem);
        e.idx  = 3'(m_idx);
        e.rem  = 32'(m_rem);
        e.pend = m_pend;
        for (int c = 0; c < NC; c++) e.miss[c*MW +: MW] = 16'(m_miss[c]);
        sb_q.push_back(e);
        for (int c = 0; c < NC; c++) begin
            h = rq[c] & ~e.tx[c];
            if (h && !m_held[c] && m_miss[c] < 65535) m_miss[c]++;
            m_held[c] = h;
        end
        if (wr) begin
            m_dur[1-m_bank][widx] = wdur;
            m_msk[1-m_bank][widx] = wmsk;
        end
        if (st || (m_run && m_rem == 1)) begin
            wrap_m = st || (m_idx + 1 == m_len);
            take   = wrap_m && m_pend;
            if (take) begin m_bank = 1 - m_bank; m_len = m_plen; m_pend = 0; end
            nidx  = wrap_m ? 0 : m_idx + 1;
            m_idx = nidx;
            m_rem = (m_dur[m_bank][nidx] == 0) ? 1 : m_dur[m_bank][nidx];
            m_run = 1;
        end else if (m_run) begin
            m_rem--;
        end
        if (sw) begin
            m_pend = 1;
            m_plen = (slen < 1) ? 1 : ((slen > 8) ? 8 : slen);
        end
    endtask

    task automatic tick(input logic [7:0] rq);
        step(0, 0, 0, rq, 0, 0, 0, 8'h00);
    endtask
    task automatic wr_entry(input int i, input int d, input logic [7:0] m, input logic [7:0] rq);
        step(0, 0, 0, rq, 1, i, d, m);
    endtask
    task automatic do_swap(input int n, input logic [7:0] rq);
        step(0, 1, n, rq, 0, 0, 0, 8'h00);
    endtask
    task automatic do_start(input logic [7:0] rq);
        step(1, 0, 0, rq, 0, 0, 0, 8'h00);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Monitor: compare every expected item with the outputs in the same clock.
    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #5;
            while (sb_q.size() != 0) begin
                e = sb_q.pop_front();
                check("R3 gate open",       {120'd0, gate_open_o}, {120'd0, e.open});
                check("R4 transmit enable", {120'd0, tx_en_o},     {120'd0, e.tx});
                check("R2 slot index",      {125'd0, slot_idx_o},  {125'd0, e.idx});
                check("R2 slot remaining",  {96'd0, slot_rem_o},   {96'd0, e.rem});
                check("R7 swap pending",    {127'd0, swap_pend_o}, {127'd0, e.pend});
                check("R5 miss counters",   miss_cnt_o,            e.miss);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin : watchdog
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog [%s] actual=running expected=finished", phase);
            summary();
            $finish;
        end
    end

    initial begin : stimulus
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 8; i++) begin m_dur[b][i] = 0; m_msk[b][i] = 8'h00; end
        for (int c = 0; c < NC; c++) begin
            m_miss[c] = 0; m_held[c] = 0;
            flen_i[c*FW +: FW] = 16'(flen_tab[c]);
        end
        m_bank = 0; m_idx = 0; m_rem = 0; m_len = 1; m_plen = 1; m_run = 0; m_pend = 0;
        rst_n = 1'b0; start_i = 0; cfg_wr_i = 0; swap_req_i = 0; cfg_idx_i = '0;
        cfg_dur_i = '0; cfg_mask_i = '0; swap_len_i = '0; req_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        phase = "R1 reset state";
        tick(8'h00); tick(8'h00);

        phase = "R6 shadow programming while idle";
        wr_entry(0, 5, 8'h05, 8'h00);
        wr_entry(1, 3, 8'h02, 8'h00);
        wr_entry(2, 4, 8'hF8, 8'h00);

        phase = "R7 swap request before start";
        do_swap(3, 8'h00); tick(8'h00);

        phase = "R2 first list walk and wrap";
        do_start(8'h00);
        repeat (40) tick(rnd());

        phase = "R6 shadow writes while running";
        wr_entry(0, 2, 8'hFF, rnd());
        wr_entry(1, 0, 8'h00, rnd());
        wr_entry(2, 6, 8'h81, rnd());
        wr_entry(3, 1, 8'h10, rnd());

        phase = "R7 mid-cycle swap waits for wrap";
        do_swap(4, rnd());
        repeat (6) tick(rnd());

        phase = "R9 zero duration in new list";
        repeat (30) tick(rnd());

        phase = "R8 restart mid-cycle";
        repeat (3) tick(rnd());
        do_start(rnd());
        repeat (12) tick(rnd());

        phase = "R5 one miss per held frame";
        repeat (20) tick(8'h08);
        tick(8'h00);
        repeat (5) tick(8'h08);

        phase = "R4 guard band with every class requesting";
        repeat (24) tick(8'hFF);

        @(negedge clk);
        #6;
        done = 1;
        summary();
        $finish;
    end

endmodule